// File: doc/BRIEF.md
# Interrupt Request Sampling Unit

This unit decides, at each instruction boundary of a processor core, whether an interrupt is taken and which kind. It watches two request sources. The first is a level-sensitive maskable request, which is looked at only in the final clock of an instruction and only while the core's interrupt-enable flag is set. The second is a non-maskable input that reacts to rising edges. An edge is latched and stays pending until it is serviced.

When a boundary arrives, a pending non-maskable event wins. The unit pulses a service strobe, presents the fixed vector type 2 and pulses a clear-enable output so the core drops its interrupt-enable flag. Otherwise, if the maskable request is present and enabled, the unit drives a one-clock acknowledge and clears the enable flag. It captures an externally supplied 8-bit type code at the clock edge that closes the acknowledge, then pulses a maskable service strobe together with that code. Stacking state, reading the vector table and single-step traps belong to the core.

Top module: `irq_sampler`

## Requirements
- R1: Reset is synchronous and active high. It is asserted for at least four clocks. While reset is asserted and in the first cycle after it, every output is 0, the vector is 0 and nothing is pending. A non-maskable input that is already high when reset is released is not treated as an edge.
- R2: A rising edge on `nmi_in` sets a pending latch at that clock. The latch survives any number of clocks without a boundary. It is cleared once the event is serviced, so a later boundary with no new edge services nothing.
- R3: `int_req` is sampled only in a clock where `instr_end` is 1. A request present in other clocks produces no acknowledge.
- R4: A maskable request is accepted only when `ien` is 1. `ien` has no effect on non-maskable service.
- R5: When a non-maskable event is pending at a boundary, it is serviced and the maskable request is not acknowledged in that boundary. The maskable request is then taken at a later boundary if it is still present and enabled.
- R6: Non-maskable service appears as `svc_nmi` high for exactly one clock, following the boundary clock, with `vec` equal to 2.
- R7: Maskable acceptance drives `inta` high for exactly one clock, following the boundary clock. `type_in` is sampled at the edge that ends that clock. In the next clock `svc_int` is high for one clock and `vec` holds the sampled code. `vec` keeps its last value afterwards.
- R8: `clr_if` is high for one clock together with `svc_nmi`, and for one clock together with `inta`.
- R9: While `inta` is high, `instr_end` is ignored, so no second acceptance starts in that clock.
- R10: A new rising edge on `nmi_in` in the same clock as a boundary that services an earlier pending event leaves the latch set. A second service follows at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 1 | Maskable request, level sensitive |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| ien | input | 1 | Core interrupt-enable flag |
| instr_end | input | 1 | High in the last clock of an instruction |
| type_in | input | 8 | Type code supplied during the acknowledge |
| inta | output | 1 | Maskable acknowledge, one clock |
| svc_nmi | output | 1 | Service non-maskable interrupt strobe |
| svc_int | output | 1 | Service maskable interrupt strobe |
| clr_if | output | 1 | Request to clear the core enable flag |
| vec | output | 8 | Interrupt type number |

## Verification
The bench targets the boundary-only sampling of the maskable line. A unit that sampled every clock would acknowledge before the instruction ended. It drives a non-maskable level that is already high across reset release; a unit that does not reload its edge history during reset would invent an event. It also drives a fresh edge in exactly the clock that services an earlier one, and a unit that clears the latch last would lose that event. Two more cases are a simultaneous maskable request, which a wrong priority would acknowledge, and a boundary held high through the acknowledge clock, which would start a second acceptance if it were not masked.

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] NMI_TYPE = VEC_W'(2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_req,
  input  logic             nmi_in,
  input  logic             ien,
  input  logic             instr_end,
  input  logic [VEC_W-1:0] type_in,
  output logic             inta,
  output logic             svc_nmi,
  output logic             svc_int,
  output logic             clr_if,
  output logic [VEC_W-1:0] vec
);

  logic nmi_last, nmi_pend;

  wire nmi_edge = nmi_in & ~nmi_last;
  wire boundary = instr_end & ~inta;
  wire take_nmi = boundary & nmi_pend;
  wire take_int = boundary & ~nmi_pend & int_req & ien;

  always_ff @(posedge clk) begin
    nmi_last <= nmi_in;
    if (rst) begin
      nmi_pend <= 1'b0;
      inta     <= 1'b0;
      svc_nmi  <= 1'b0;
      svc_int  <= 1'b0;
      clr_if   <= 1'b0;
      vec      <= '0;
    end else begin
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_edge;
      inta     <= take_int;
      svc_nmi  <= take_nmi;
      svc_int  <= inta;
      clr_if   <= take_nmi | take_int;
      if (take_nmi)  vec <= NMI_TYPE;
      else if (inta) vec <= type_in;
    end
  end

  AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_in) |=> nmi_pend); // R2
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (rst)
    inta |-> $past(instr_end && int_req && ien)); // R3
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
    !(svc_nmi && inta)); // R5
  AST_NMI_TYPE: assert property (@(posedge clk) disable iff (rst)
    svc_nmi |-> vec == NMI_TYPE); // R6
  AST_TYPE_DELIVER: assert property (@(posedge clk) disable iff (rst)
    inta |=> (svc_int && vec == $past(type_in))); // R7
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (svc_nmi || inta) |-> clr_if); // R8
  AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (rst)
    inta |=> !inta); // R9

endmodule

// File: tb/tb_irq_sampler.sv
module tb_irq_sampler;
  logic clk = 0, rst = 1, int_req = 0, nmi_in = 0, ien = 0, instr_end = 0;
  logic [7:0] type_in = 0;
  logic inta, svc_nmi, svc_int, clr_if;
  logic [7:0] vec;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_sampler dut (.clk, .rst, .int_req, .nmi_in, .ien, .instr_end, .type_in,
                   .inta, .svc_nmi, .svc_int, .clr_if, .vec);

  task automatic chk(input int act, input int exp, input string msg);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic drv(input logic b, input logic r, input logic n);
    @(negedge clk); instr_end = b; int_req = r; nmi_in = n;
  endtask

  task automatic outs_idle(input string msg);
    chk(inta, 0, {msg, " inta"});
    chk(svc_nmi, 0, {msg, " svc_nmi"});
    chk(svc_int, 0, {msg, " svc_int"});
    chk(clr_if, 0, {msg, " clr_if"});
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; nmi_in = 1; ien = 1;
    for (int i = 0; i < 4; i++) step();
    outs_idle("R1 during reset");
    chk(vec, 0, "R1 vec in reset");
    @(negedge clk); rst = 0; step();
    outs_idle("R1 after release");
    drv(1, 0, 1); step();
    chk(svc_nmi, 0, "R1 held level not an edge");
    drv(0, 0, 0); step();
    drv(1, 0, 0); step();
    chk(svc_nmi, 0, "R1 still nothing pending");
    drv(0, 0, 0);
  endtask

  task automatic t_reset_clears;
    drv(0, 0, 1); drv(0, 0, 0);
    @(negedge clk); rst = 1;
    for (int i = 0; i < 4; i++) step();
    @(negedge clk); rst = 0;
    drv(1, 0, 0); step();
    chk(svc_nmi, 0, "R1 reset clears pending");
    drv(0, 0, 0);
  endtask

  task automatic t_nmi;
    drv(0, 0, 1); drv(0, 0, 1); drv(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(); chk(svc_nmi, 0, "R2 no service without boundary");
    end
    drv(1, 0, 0); step();
    chk(svc_nmi, 1, "R6 svc_nmi"); chk(vec, 2, "R6 vec");
    chk(clr_if, 1, "R8 clr_if with nmi");
    drv(0, 0, 0); step();
    chk(svc_nmi, 0, "R6 one clock"); chk(vec, 2, "R7 vec holds");
    drv(1, 0, 0); step();
    chk(svc_nmi, 0, "R2 latch cleared after service");
    drv(0, 0, 0);
  endtask

  task automatic t_sample;
    ien = 1;
    for (int i = 0; i < 3; i++) begin
      drv(0, 1, 0); step(); chk(inta, 0, "R3 no sample off boundary");
    end
    drv(1, 1, 0); type_in = 8'h00; step();
    chk(inta, 1, "R7 inta"); chk(clr_if, 1, "R8 clr_if with inta");
    @(negedge clk); type_in = 8'hA5; step();
    chk(svc_int, 1, "R7 svc_int"); chk(vec, 8'hA5, "R7 vec code");
    chk(inta, 0, "R9 boundary ignored during inta");
    drv(0, 0, 0); type_in = 8'h11; step();
    chk(svc_int, 0, "R7 one clock"); chk(vec, 8'hA5, "R7 vec holds");
  endtask

  task automatic t_ien;
    ien = 0;
    drv(1, 1, 0); step();
    chk(inta, 0, "R4 disabled no inta");
    drv(0, 1, 1); drv(0, 1, 0);
    drv(1, 1, 0); step();
    chk(svc_nmi, 1, "R4 nmi ignores ien"); chk(inta, 0, "R4 still no inta");
    drv(0, 0, 0); ien = 1;
  endtask

  task automatic t_prio;
    ien = 1;
    drv(0, 0, 1); drv(0, 0, 0);
    drv(1, 1, 0); step();
    chk(svc_nmi, 1, "R5 nmi first"); chk(inta, 0, "R5 no inta same boundary");
    drv(0, 1, 0); step();
    drv(1, 1, 0); step();
    chk(inta, 1, "R5 maskable later");
    drv(0, 0, 0); type_in = 8'h3C; step();
    chk(svc_int, 1, "R5 svc_int"); chk(vec, 8'h3C, "R7 second code");
  endtask

  task automatic t_edge_at_boundary;
    drv(0, 0, 1); drv(0, 0, 0);
    drv(1, 0, 1); step();
    chk(svc_nmi, 1, "R10 first service");
    drv(1, 0, 0); step();
    chk(svc_nmi, 1, "R10 new edge kept");
    drv(1, 0, 0); step();
    chk(svc_nmi, 0, "R10 no third");
    drv(0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_nmi();
    t_sample();
    t_ien();
    t_prio();
    t_edge_at_boundary();
    t_reset_clears();
    repeat (3) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule